// File: doc/BRIEF.md
# Regulator Rail Fault Supervisor

This block watches one or more regulator rails for undervoltage, overcurrent and short-circuit. The three conditions arrive from analog comparators, one bit per rail each. The block also receives each rail's enable and a flag that is high while the rail's output voltage is moving. From the power sequencer it takes the current power state and a strobe that marks the end of a sequencing slot. Each comparator input is qualified before it counts as a fault. Undervoltage and overcurrent are ignored while the rail is moving. Overcurrent must persist for a deglitch time, which is either short or long. Short-circuit is ignored for a programmable window after the rail is switched on. Undervoltage may be masked per rail.

Each qualified fault sets a sticky per-rail flag. Software clears a flag by writing a one to it. An overcurrent or short-circuit also switches its own rail off at once. Any unmasked fault asks the sequencer to power down. How the request is timed depends on the power state. In the active or standby state the request is raised on the next clock. While the sequencer is still bringing rails up, the request is held back until the current slot ends. A single fault-clear pulse drops the power-down request and the rail shut-offs.

Top module: `rail_fault_supervisor`

## Requirements
- R1: An undervoltage input counts only while its rail is enabled and not ramping. A counted undervoltage sets that rail's `uv_flag` at the next clock edge. The flag is set whether or not the rail's mask is set.
- R2: An overcurrent input is counted only while its rail is enabled and not ramping. It must stay high for 4 consecutive counted cycles when `oc_long_dg`=0, or 32 when it is 1. On the edge that ends that run, `oc_flag` and `rail_off` for the rail go high. A break in the run, or a ramping cycle, restarts the count.
- R3: Let cycle k be the first cycle in which `rail_en` is high, and B the value of `scg_blank_len`. A short-circuit input is ignored in cycles k through k+B. From cycle k+B+1 on, a high short-circuit input sets `scg_flag` and `rail_off` at the next edge.
- R4: An undervoltage on a rail whose `uv_mask` bit is set still sets its flag but never contributes to `pd_req`.
- R5: Power state encoding is 2'b00 off, 2'b01 sequencing up, 2'b10 active, 2'b11 standby. In the sequencing-up state a fault is held pending. `pd_req` rises at the edge that closes the first cycle in which `slot_end` is high, counting the fault cycle itself.
- R6: In the active or standby state, an unmasked undervoltage, a confirmed overcurrent or a qualified short-circuit raises `pd_req` at the next edge.
- R7: Once high, `pd_req` stays high until a cycle with `fault_clr` high. That cycle also clears every `rail_off` bit and any pending request. A fault in the same cycle wins over the clear.
- R8: A `*_flag_clr` bit clears its flag at the next edge. A fault that sets the same flag in the same cycle wins over the clear.
- R9: While `rst_n` is low, every output is zero.
- R10: In the off state, faults set flags and `rail_off` but do not raise `pd_req`.
- R11: An undervoltage never sets `rail_off`. Only overcurrent and short-circuit do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_state | input | 2 | Sequencer power state (encoding in R5) |
| slot_end | input | 1 | End-of-slot strobe from the sequencer |
| rail_en | input | NUM_RAILS | Rail enable per rail |
| rail_ramp | input | NUM_RAILS | Output voltage transition in progress |
| uv_det | input | NUM_RAILS | Undervoltage comparator |
| oc_det | input | NUM_RAILS | Overcurrent comparator |
| scg_det | input | NUM_RAILS | Short-circuit comparator |
| uv_mask | input | NUM_RAILS | Undervoltage power-down mask |
| oc_long_dg | input | 1 | Selects the long overcurrent deglitch |
| scg_blank_len | input | BLANK_W | Short-circuit blanking length in cycles |
| uv_flag_clr | input | NUM_RAILS | Write-one-to-clear for uv_flag |
| oc_flag_clr | input | NUM_RAILS | Write-one-to-clear for oc_flag |
| scg_flag_clr | input | NUM_RAILS | Write-one-to-clear for scg_flag |
| fault_clr | input | 1 | Clears pd_req, the pending request and rail_off |
| rail_off | output | NUM_RAILS | Immediate rail disable |
| pd_req | output | 1 | Power-down request |
| uv_flag | output | NUM_RAILS | Sticky undervoltage flag |
| oc_flag | output | NUM_RAILS | Sticky overcurrent flag |
| scg_flag | output | NUM_RAILS | Sticky short-circuit flag |

## Verification
Every output is registered. A flag or `rail_off` therefore changes at the edge that closes the cycle in which its fault qualified: one edge after the input for undervoltage and short-circuit, and on the 4th or 32nd edge of an overcurrent run. `pd_req` changes one edge after the fault in active or standby, and one edge after the `slot_end` cycle in sequencing-up. The bench drives inputs 1 ns after a falling edge. At each rising edge it advances a behavioural model, kept with integer run lengths and rail ages, and at the next falling edge it compares all five outputs with that model. That falling edge is exactly where each result above is due.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    typedef enum logic [1:0] {
        PS_OFF     = 2'b00,
        PS_SEQ_UP  = 2'b01,
        PS_ACTIVE  = 2'b10,
        PS_STANDBY = 2'b11
    } pwr_state_e;
endpackage

// File: rtl/rfs_rail_chan.sv
module rfs_rail_chan #(
    parameter int SHORT_DG = 4,
    parameter int LONG_DG  = 32,
    parameter int BLANK_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rail_en,
    input  logic               rail_ramp,
    input  logic               uv_raw,
    input  logic               oc_raw,
    input  logic               scg_raw,
    input  logic               oc_long,
    input  logic [BLANK_W-1:0] blank_len,
    input  logic               clr_uv,
    input  logic               clr_oc,
    input  logic               clr_scg,
    input  logic               fault_clr,
    output logic               uv_hit,
    output logic               kill_hit,
    output logic               uv_flag,
    output logic               oc_flag,
    output logic               scg_flag,
    output logic               rail_kill
);
    localparam int CNT_W = $clog2(LONG_DG + 1);
    localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_DG - 1);
    localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_DG - 1);

    typedef struct packed {
        logic [CNT_W-1:0]   oc_run;
        logic [BLANK_W-1:0] blank;
        logic               en_prev;
        logic               uvf;
        logic               ocf;
        logic               scgf;
        logic               kill;
    } chan_t;

    chan_t st_q, st_d;
    logic armed, en_rise, uv_q, oc_q, oc_hit, scg_hit;
    logic [CNT_W-1:0] lim;

    always_comb begin
        st_d    = st_q;
        en_rise = rail_en & ~st_q.en_prev;
        armed   = rail_en & ~rail_ramp;
        lim     = oc_long ? LONG_LIM : SHORT_LIM;
        uv_q    = uv_raw & armed;
        oc_q    = oc_raw & armed;
        oc_hit  = oc_q & (st_q.oc_run >= lim);
        scg_hit = scg_raw & rail_en & ~en_rise & (st_q.blank == '0);

        if (!oc_q)
            st_d.oc_run = '0;
        else if (st_q.oc_run < lim)
            st_d.oc_run = st_q.oc_run + 1'b1;

        if (en_rise)
            st_d.blank = blank_len;
        else if (st_q.blank != '0)
            st_d.blank = st_q.blank - 1'b1;

        st_d.en_prev = rail_en;
        st_d.uvf  = (st_q.uvf  & ~clr_uv)    | uv_q;
        st_d.ocf  = (st_q.ocf  & ~clr_oc)    | oc_hit;
        st_d.scgf = (st_q.scgf & ~clr_scg)   | scg_hit;
        st_d.kill = (st_q.kill & ~fault_clr) | oc_hit | scg_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign uv_hit    = uv_q;
    assign kill_hit  = oc_hit | scg_hit;
    assign uv_flag   = st_q.uvf;
    assign oc_flag   = st_q.ocf;
    assign scg_flag  = st_q.scgf;
    assign rail_kill = st_q.kill;

    // R1
    uv_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uv_flag) |-> $past(uv_raw && rail_en && !rail_ramp));
    // R2
    oc_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oc_flag) |-> $past(oc_raw && rail_en && !rail_ramp));
    // R3
    scg_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scg_flag) |-> ($past(rail_en, 1) && $past(rail_en, 2)));
    // R11
    kill_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_kill) |-> $past(oc_raw || scg_raw));
endmodule

// File: rtl/rfs_pd_ctrl.sv
module rfs_pd_ctrl
    import rfs_pkg::*;
#(
    parameter int NUM_RAILS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           pwr_state,
    input  logic                 slot_end,
    input  logic                 fault_clr,
    input  logic [NUM_RAILS-1:0] uv_hits,
    input  logic [NUM_RAILS-1:0] uv_mask,
    input  logic [NUM_RAILS-1:0] kill_hits,
    output logic                 pd_req
);
    typedef struct packed {
        logic pending;
        logic req;
    } pd_t;

    pd_t pd_q, pd_d;
    logic fault, seq_fault, imm_fault, release_now;
    pwr_state_e ps;

    always_comb begin
        ps          = pwr_state_e'(pwr_state);
        fault       = |(uv_hits & ~uv_mask) | (|kill_hits);
        seq_fault   = fault & (ps == PS_SEQ_UP);
        imm_fault   = fault & ((ps == PS_ACTIVE) || (ps == PS_STANDBY));
        pd_d.pending = (pd_q.pending & ~fault_clr) | seq_fault;
        release_now = slot_end & pd_d.pending;
        if (release_now) pd_d.pending = 1'b0;
        pd_d.req = (pd_q.req & ~fault_clr) | imm_fault | release_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pd_q <= '0;
        else        pd_q <= pd_d;
    end

    assign pd_req = pd_q.req;

    // R5
    pd_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_req) |-> $past(slot_end || pwr_state[1]));
    // R7
    pd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_req && !fault_clr) |=> pd_req);
endmodule

// File: rtl/rail_fault_supervisor.sv
module rail_fault_supervisor #(
    parameter int NUM_RAILS = 2,
    parameter int SHORT_DG  = 4,
    parameter int LONG_DG   = 32,
    parameter int BLANK_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           pwr_state,
    input  logic                 slot_end,
    input  logic [NUM_RAILS-1:0] rail_en,
    input  logic [NUM_RAILS-1:0] rail_ramp,
    input  logic [NUM_RAILS-1:0] uv_det,
    input  logic [NUM_RAILS-1:0] oc_det,
    input  logic [NUM_RAILS-1:0] scg_det,
    input  logic [NUM_RAILS-1:0] uv_mask,
    input  logic                 oc_long_dg,
    input  logic [BLANK_W-1:0]   scg_blank_len,
    input  logic [NUM_RAILS-1:0] uv_flag_clr,
    input  logic [NUM_RAILS-1:0] oc_flag_clr,
    input  logic [NUM_RAILS-1:0] scg_flag_clr,
    input  logic                 fault_clr,
    output logic [NUM_RAILS-1:0] rail_off,
    output logic                 pd_req,
    output logic [NUM_RAILS-1:0] uv_flag,
    output logic [NUM_RAILS-1:0] oc_flag,
    output logic [NUM_RAILS-1:0] scg_flag
);
    logic [NUM_RAILS-1:0] uv_hits, kill_hits;

    for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
        rfs_rail_chan #(
            .SHORT_DG(SHORT_DG),
            .LONG_DG (LONG_DG),
            .BLANK_W (BLANK_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .rail_en  (rail_en[r]),
            .rail_ramp(rail_ramp[r]),
            .uv_raw   (uv_det[r]),
            .oc_raw   (oc_det[r]),
            .scg_raw  (scg_det[r]),
            .oc_long  (oc_long_dg),
            .blank_len(scg_blank_len),
            .clr_uv   (uv_flag_clr[r]),
            .clr_oc   (oc_flag_clr[r]),
            .clr_scg  (scg_flag_clr[r]),
            .fault_clr(fault_clr),
            .uv_hit   (uv_hits[r]),
            .kill_hit (kill_hits[r]),
            .uv_flag  (uv_flag[r]),
            .oc_flag  (oc_flag[r]),
            .scg_flag (scg_flag[r]),
            .rail_kill(rail_off[r])
        );
    end

    rfs_pd_ctrl #(.NUM_RAILS(NUM_RAILS)) u_pd (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_state(pwr_state),
        .slot_end (slot_end),
        .fault_clr(fault_clr),
        .uv_hits  (uv_hits),
        .uv_mask  (uv_mask),
        .kill_hits(kill_hits),
        .pd_req   (pd_req)
    );

    // R9
    reset_clean_chk: assert property (@(posedge clk)
        !rst_n |=> (pd_req == 1'b0 || !rst_n));
endmodule

// File: tb/tb_rail_fault_supervisor.sv
`timescale 1ns/1ps
module tb_rail_fault_supervisor;
    localparam int NR = 2;
    localparam int BW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] pwr_state = 2'b00;
    logic slot_end = 0, oc_long_dg = 0, fault_clr = 0;
    logic [NR-1:0] rail_en = '0, rail_ramp = '0, uv_det = '0, oc_det = '0, scg_det = '0;
    logic [NR-1:0] uv_mask = '0, uv_flag_clr = '0, oc_flag_clr = '0, scg_flag_clr = '0;
    logic [BW-1:0] scg_blank_len = 16'd6;
    logic [NR-1:0] rail_off, uv_flag, oc_flag, scg_flag;
    logic pd_req;

    rail_fault_supervisor #(.NUM_RAILS(NR)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .slot_end(slot_end),
        .rail_en(rail_en), .rail_ramp(rail_ramp), .uv_det(uv_det), .oc_det(oc_det),
        .scg_det(scg_det), .uv_mask(uv_mask), .oc_long_dg(oc_long_dg),
        .scg_blank_len(scg_blank_len), .uv_flag_clr(uv_flag_clr),
        .oc_flag_clr(oc_flag_clr), .scg_flag_clr(scg_flag_clr), .fault_clr(fault_clr),
        .rail_off(rail_off), .pd_req(pd_req), .uv_flag(uv_flag), .oc_flag(oc_flag),
        .scg_flag(scg_flag)
    );

    always #10 clk = ~clk;

    // behavioural reference
    int  run_len [NR];
    int  age     [NR];
    bit  en_was  [NR];
    bit  e_uv [NR], e_oc [NR], e_scg [NR], e_off [NR];
    bit  e_pd, e_pend;

    initial for (int r = 0; r < NR; r++) age[r] = 1000000;

    always @(posedge clk) begin
        bit flt;
        flt = 0;
        if (!rst_n) begin
            for (int r = 0; r < NR; r++) begin
                run_len[r] = 0; age[r] = 1000000; en_was[r] = 0;
                e_uv[r] = 0; e_oc[r] = 0; e_scg[r] = 0; e_off[r] = 0;
            end
            e_pd = 0; e_pend = 0;
        end else begin
            for (int r = 0; r < NR; r++) begin
                bit live, uvx, ocx, scx;
                int need;
                need = oc_long_dg ? 32 : 4;
                live = rail_en[r] && !rail_ramp[r];
                if (rail_en[r] && !en_was[r]) age[r] = 0;
                else if (age[r] < 1000000) age[r]++;
                en_was[r] = rail_en[r];
                uvx = uv_det[r] && live;
                if (oc_det[r] && live) run_len[r]++; else run_len[r] = 0;
                ocx = run_len[r] >= need;
                scx = scg_det[r] && rail_en[r] && (age[r] >= int'(scg_blank_len) + 1);
                e_uv[r]  = (e_uv[r]  && !uv_flag_clr[r])  || uvx;
                e_oc[r]  = (e_oc[r]  && !oc_flag_clr[r])  || ocx;
                e_scg[r] = (e_scg[r] && !scg_flag_clr[r]) || scx;
                e_off[r] = (e_off[r] && !fault_clr) || ocx || scx;
                if ((uvx && !uv_mask[r]) || ocx || scx) flt = 1;
            end
            if (fault_clr) begin e_pd = 0; e_pend = 0; end
            if (flt && pwr_state == 2'b01) e_pend = 1;
            if (flt && pwr_state[1]) e_pd = 1;
            if (slot_end && e_pend) begin e_pd = 1; e_pend = 0; end
        end
    end

    int checks = 0, fails = 0;
    string tag = "R9";
    bit done = 0;

    task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (!done) begin
        logic [NR-1:0] xu, xo, xs, xk;
        for (int r = 0; r < NR; r++) begin
            xu[r] = e_uv[r]; xo[r] = e_oc[r]; xs[r] = e_scg[r]; xk[r] = e_off[r];
        end
        cmp("uv_flag (R1/R8)", 32'(uv_flag), 32'(xu));
        cmp("oc_flag (R2)", 32'(oc_flag), 32'(xo));
        cmp("scg_flag (R3)", 32'(scg_flag), 32'(xs));
        cmp("rail_off (R11)", 32'(rail_off), 32'(xk));
        cmp("pd_req (R5/R6/R7)", 32'(pd_req), 32'(e_pd));
    end

    task automatic tick(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic clear_all();
        uv_flag_clr = '1; oc_flag_clr = '1; scg_flag_clr = '1; fault_clr = 1;
        tick(1);
        uv_flag_clr = '0; oc_flag_clr = '0; scg_flag_clr = '0; fault_clr = 0;
        tick(1);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual running expected finished");
        finish_run();
    end

    initial begin
        // R9: reset state
        tick(3);
        rst_n = 1; tick(1);
        // R1: blanking while ramping, then detection
        tag = "R1";
        rail_en = 2'b11; rail_ramp = 2'b11; uv_det = 2'b11; tick(5);
        rail_ramp = 2'b00; tick(1);
        uv_det = 2'b00; tick(2);
        // R8: clear, set-wins
        tag = "R8";
        uv_flag_clr = 2'b11; tick(1);
        uv_flag_clr = 2'b01; uv_det = 2'b01; tick(1);
        uv_flag_clr = 2'b00; uv_det = 2'b00; tick(2);
        uv_flag_clr = 2'b01; tick(1); uv_flag_clr = 2'b00; tick(1);
        // R1: disabled rail ignored
        tag = "R1";
        rail_en = 2'b10; uv_det = 2'b01; tick(3);
        uv_det = 2'b00; rail_en = 2'b11; tick(2);
        // R2 / R10 / R11: short deglitch in off state
        tag = "R2";
        oc_det = 2'b01; tick(3); oc_det = 2'b00; tick(1);
        oc_det = 2'b01; tick(5); oc_det = 2'b00; tick(2);
        tag = "R10"; tick(2);
        clear_all();
        tag = "R2";
        oc_long_dg = 1; oc_det = 2'b10; tick(31); oc_det = 2'b00; tick(1);
        oc_det = 2'b10; tick(10); rail_ramp = 2'b10; tick(2); rail_ramp = 2'b00; tick(40);
        oc_det = 2'b00; oc_long_dg = 0; tick(2);
        clear_all();
        // R3: short-circuit blanking after enable
        tag = "R3";
        rail_en = 2'b01; tick(2);
        scg_det = 2'b10; rail_en = 2'b11; tick(12);
        scg_det = 2'b00; tick(2);
        clear_all();
        // R4: masked undervoltage in active state
        tag = "R4";
        pwr_state = 2'b10; uv_mask = 2'b11; uv_det = 2'b11; tick(2);
        uv_det = 2'b00; uv_mask = 2'b00; tick(3);
        clear_all();
        // R5: deferred request while sequencing up
        tag = "R5";
        pwr_state = 2'b01; uv_det = 2'b01; tick(1); uv_det = 2'b00; tick(4);
        slot_end = 1; tick(1); slot_end = 0; tick(3);
        clear_all();
        oc_det = 2'b10; tick(6); oc_det = 2'b00; tick(3);
        slot_end = 1; tick(1); slot_end = 0; tick(2);
        clear_all();
        // R6 / R7: immediate request, stickiness
        tag = "R6";
        pwr_state = 2'b10; oc_det = 2'b01; tick(5); oc_det = 2'b00; tick(2);
        tag = "R7";
        tick(5); fault_clr = 1; tick(1); fault_clr = 0; tick(2);
        tag = "R6";
        pwr_state = 2'b11; uv_det = 2'b10; tick(1); uv_det = 2'b00; tick(3);
        clear_all();
        // R10: off state, short-circuit
        tag = "R10";
        pwr_state = 2'b00; scg_det = 2'b01; tick(2); scg_det = 2'b00; tick(3);
        clear_all();
        finish_run();
    end
endmodule